// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a 32-bit virtual address into a physical address by reading one entry from a flat page table held in memory. Addresses are split into a 10-bit page offset (1024-byte pages) and a 22-bit virtual page number. Two context registers describe the running task: a table base address and a table size in entries. The operating system rewrites both on every task switch.

A request is accepted only while the block is idle. The page number is first compared with the table size. A page number outside the table ends the translation at once with a bound fault, and no memory read is issued. Otherwise the block reads the entry at `base + 4*vpn` through a request/acknowledge read port and waits as long as memory needs. The entry's valid bit and its read or write permission are then checked against the access type. On success the physical page number from the entry replaces the virtual one, and the offset passes through unchanged.

Only one translation is in flight at a time. The result is presented for exactly one cycle.

Top module: `pt_xlate`

## Requirements
- R1: After reset, busy_o, mem_req_o and rsp_valid_o are low, and the table size register is 0, so every request returns fault 01.
- R2: A request is accepted at a clock edge where req_valid_i is high and busy_o is low. busy_o is high from the cycle after acceptance through the response cycle. A request presented while busy_o is high is ignored.
- R3: If the virtual page number (vaddr[31:10]) is greater than or equal to the size register, the response comes in the cycle after acceptance with fault 01 and mem_req_o is never raised.
- R4: An in-range request raises mem_req_o in the cycle after acceptance, with mem_addr_o = base + 4*vpn. Both stay unchanged until the edge at which mem_ack_i is sampled high, for any number of wait cycles. mem_ack_i has no effect while mem_req_o is low.
- R5: A table entry is 32 bits: bit 0 valid, bit 1 read allowed, bit 2 write allowed, bits 31:10 physical page number. Bits 9:3 are ignored.
- R6: An entry with bit 0 clear returns fault 10, whatever its permission bits.
- R7: A valid entry returns fault 11 when the access needs a permission the entry lacks. A read access (req_write_i = 0) needs bit 1, and a write access needs bit 2.
- R8: A permitted access returns fault 00 and rsp_paddr_o = {entry[31:10], vaddr[9:0]}.
- R9: rsp_valid_o is high for exactly one cycle: the cycle after the acknowledge edge, or the cycle after acceptance for a bound fault. With any nonzero fault code, rsp_paddr_o is 0.
- R10: A context write (ctx_we_i) loads base and size at the clock edge. It affects only requests accepted after that edge. A translation already accepted completes with the values it was accepted under.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctx_we_i | input | 1 | Load the context registers |
| ctx_base_i | input | 32 | New table base byte address |
| ctx_size_i | input | 23 | New table size in entries |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| busy_o | output | 1 | Translation in progress |
| mem_req_o | output | 1 | Table entry read request |
| mem_addr_o | output | 32 | Table entry byte address |
| mem_ack_i | input | 1 | Read data valid, completes the read |
| mem_rdata_i | input | 32 | Table entry read data |
| rsp_valid_o | output | 1 | Result valid, one cycle |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_fault_o | output | 2 | 00 ok, 01 out of bounds, 10 invalid, 11 permission |

## Verification
The bench tests the last in-range entry and the first out-of-range entry. An off-by-one bound compare would either read past the table or reject a legal page. It gives entries with every mix of permission bits, including invalid entries that carry both permissions, so the bench catches a swapped fault priority or a read/write mix-up. It varies the acknowledge latency from zero upward and sends acknowledges while no read is pending, which exposes a block that drops its request early or takes a stray acknowledge. It also rewrites the context and re-requests during a pending read, which exposes a block that re-reads its registers mid-translation or accepts a second request.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int VA_W_DEF  = 32;
  localparam int OFF_W_DEF = 10;
  localparam int PTE_V_BIT = 0;
  localparam int PTE_R_BIT = 1;
  localparam int PTE_W_BIT = 2;

  typedef enum logic [1:0] {
    FLT_OK      = 2'b00,
    FLT_BOUND   = 2'b01,
    FLT_INVALID = 2'b10,
    FLT_PERM    = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RESP
  } state_e;
endpackage

// File: rtl/pt_ctx_regs.sv
module pt_ctx_regs #(
  parameter int VA_W   = 32,
  parameter int SIZE_W = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [VA_W-1:0]   base_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [VA_W-1:0]   base_o,
  output logic [SIZE_W-1:0] size_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      size_o <= '0;
    end else if (we_i) begin
      base_o <= base_i;
      size_o <= size_i;
    end
  end

  AST_CTX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (base_o == $past(base_i) && size_o == $past(size_i))); // R10
endmodule

// File: rtl/pt_bound_chk.sv
module pt_bound_chk #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 10,
  parameter int SIZE_W = 23
) (
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [VA_W-1:0]   base_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              in_range_o,
  output logic [VA_W-1:0]   pte_addr_o
);
  localparam int VPN_W = VA_W - OFF_W;

  logic [VPN_W-1:0] vpn;
  logic [VA_W-1:0]  idx_bytes;

  assign vpn        = vaddr_i[VA_W-1:OFF_W];
  assign idx_bytes  = {{(OFF_W-2){1'b0}}, vpn, 2'b00};
  assign in_range_o = {1'b0, vpn} < size_i;
  assign pte_addr_o = base_i + idx_bytes;
endmodule

// File: rtl/pt_pte_eval.sv
module pt_pte_eval
  import pt_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10
) (
  input  logic [VA_W-1:0]  pte_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             is_write_i,
  output fault_e           fault_o,
  output logic [VA_W-1:0]  paddr_o
);
  logic need_ok;

  assign need_ok = is_write_i ? pte_i[PTE_W_BIT] : pte_i[PTE_R_BIT];

  always_comb begin
    fault_o = FLT_OK;
    paddr_o = '0;
    if (!pte_i[PTE_V_BIT])  fault_o = FLT_INVALID;
    else if (!need_ok)      fault_o = FLT_PERM;
    else                    paddr_o = {pte_i[VA_W-1:OFF_W], off_i};
  end
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
  import pt_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ctx_we_i,
  input  logic [VA_W-1:0]         ctx_base_i,
  input  logic [VA_W-OFF_W:0]     ctx_size_i,
  input  logic                    req_valid_i,
  input  logic [VA_W-1:0]         req_vaddr_i,
  input  logic                    req_write_i,
  output logic                    busy_o,
  output logic                    mem_req_o,
  output logic [VA_W-1:0]         mem_addr_o,
  input  logic                    mem_ack_i,
  input  logic [VA_W-1:0]         mem_rdata_i,
  output logic                    rsp_valid_o,
  output logic [VA_W-1:0]         rsp_paddr_o,
  output logic [1:0]              rsp_fault_o
);
  localparam int SIZE_W = VA_W - OFF_W + 1;

  logic [VA_W-1:0]   base_q;
  logic [SIZE_W-1:0] size_q;
  logic              in_range;
  logic [VA_W-1:0]   pte_addr;
  fault_e            eval_fault;
  logic [VA_W-1:0]   eval_paddr;

  state_e            state_q;
  logic [OFF_W-1:0]  off_q;
  logic              write_q;
  logic [VA_W-1:0]   addr_q;
  fault_e            fault_q;
  logic [VA_W-1:0]   paddr_q;
  logic              accept;

  pt_ctx_regs #(.VA_W(VA_W), .SIZE_W(SIZE_W)) u_ctx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctx_we_i),
    .base_i (ctx_base_i),
    .size_i (ctx_size_i),
    .base_o (base_q),
    .size_o (size_q)
  );

  pt_bound_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_bound (
    .vaddr_i    (req_vaddr_i),
    .base_i     (base_q),
    .size_i     (size_q),
    .in_range_o (in_range),
    .pte_addr_o (pte_addr)
  );

  pt_pte_eval #(.VA_W(VA_W), .OFF_W(OFF_W)) u_eval (
    .pte_i      (mem_rdata_i),
    .off_i      (off_q),
    .is_write_i (write_q),
    .fault_o    (eval_fault),
    .paddr_o    (eval_paddr)
  );

  assign accept = req_valid_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
      write_q <= 1'b0;
      addr_q  <= '0;
      fault_q <= FLT_OK;
      paddr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          off_q   <= req_vaddr_i[OFF_W-1:0];
          write_q <= req_write_i;
          addr_q  <= pte_addr;
          if (in_range) begin
            state_q <= ST_FETCH;
          end else begin
            fault_q <= FLT_BOUND;
            paddr_q <= '0;
            state_q <= ST_RESP;
          end
        end
        ST_FETCH: if (mem_ack_i) begin
          fault_q <= eval_fault;
          paddr_q <= eval_paddr;
          state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = state_q != ST_IDLE;
  assign mem_req_o   = state_q == ST_FETCH;
  assign mem_addr_o  = addr_q;
  assign rsp_valid_o = state_q == ST_RESP;
  assign rsp_paddr_o = paddr_q;
  assign rsp_fault_o = fault_q;

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !rsp_valid_o) |=> busy_o); // R2
  AST_BOUND_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && !in_range) |=>
      (rsp_valid_o && !mem_req_o && rsp_fault_o == FLT_BOUND)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == FLT_OK) |-> rsp_paddr_o[OFF_W-1:0] == off_q); // R8
  AST_ACK_TO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> rsp_valid_o); // R9
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R9
  AST_FAULT_ZERO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != FLT_OK) |-> rsp_paddr_o == '0); // R9
endmodule

// File: tb/tb_pt_xlate.sv
module tb_pt_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctx_we = 1'b0;
  logic [31:0] ctx_base = '0;
  logic [22:0] ctx_size = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        busy, mem_req, mem_ack, rsp_valid;
  logic [31:0] mem_addr, mem_rdata, rsp_paddr;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int ack_delay = 0;
  int wait_cnt = 0;
  bit stray_ack = 1'b0;
  logic [31:0] pte_mem [int unsigned];

  always #10 clk = ~clk;

  pt_xlate dut (
    .clk_i(clk), .rst_ni(rst_n), .ctx_we_i(ctx_we), .ctx_base_i(ctx_base),
    .ctx_size_i(ctx_size), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .busy_o(busy), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault)
  );

  function automatic logic [31:0] lookup(logic [31:0] a);
    if (pte_mem.exists(a)) return pte_mem[a];
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // memory responder
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; wait_cnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (wait_cnt >= ack_delay) begin
        mem_ack <= 1'b1; mem_rdata <= lookup(mem_addr);
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end else begin
      wait_cnt  <= 0;
      mem_ack   <= stray_ack && !mem_req;
      mem_rdata <= 32'hFFFF_FFFF;
    end
  end

  // behavioural reference model
  int          m_phase;
  logic [31:0] m_base, m_addr, m_pa, m_e;
  logic [22:0] m_size;
  logic [9:0]  m_off;
  logic        m_wr;
  logic [1:0]  m_fault;
  longint unsigned m_vpn;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_base = '0; m_size = '0; m_addr = '0; m_pa = '0; m_fault = '0;
      m_off = '0; m_wr = 1'b0;
    end else begin
      cycles++;
      case (m_phase)
        0: if (req_valid) begin
          m_vpn = longint'(req_vaddr) / 1024;
          m_off = req_vaddr[9:0];
          m_wr  = req_write;
          if (m_vpn >= longint'(m_size)) begin
            m_phase = 2; m_fault = 2'b01; m_pa = '0;
          end else begin
            m_phase = 1; m_addr = m_base + 32'(m_vpn * 4);
          end
        end
        1: if (mem_ack) begin
          m_e = lookup(m_addr);
          m_pa = '0;
          if (m_e[0] == 1'b0) m_fault = 2'b10;
          else if ((m_wr && !m_e[2]) || (!m_wr && !m_e[1])) m_fault = 2'b11;
          else begin m_fault = 2'b00; m_pa = {m_e[31:10], m_off}; end
          m_phase = 2;
        end
        default: m_phase = 0;
      endcase
      if (ctx_we) begin m_base = ctx_base; m_size = ctx_size; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 busy", 32'(busy), 32'(m_phase != 0));
      check("R3/R4 mem_req", 32'(mem_req), 32'(m_phase == 1));
      if (m_phase == 1) check("R4 mem_addr", mem_addr, m_addr);
      check("R9 rsp_valid", 32'(rsp_valid), 32'(m_phase == 2));
      if (m_phase == 2) begin
        check("R6/R7 fault", 32'(rsp_fault), 32'(m_fault));
        check("R8 paddr", rsp_paddr, m_pa);
      end
    end
  end

  task automatic ctx_write(logic [31:0] b, logic [22:0] s);
    @(negedge clk);
    ctx_we = 1'b1; ctx_base = b; ctx_size = s;
    @(negedge clk);
    ctx_we = 1'b0;
  endtask

  task automatic xlate(logic [31:0] va, logic wr, int dly,
                       logic [1:0] ef, logic [31:0] ep, string tag);
    ack_delay = dly;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    check({tag, " fault"}, 32'(rsp_fault), 32'(ef));
    check({tag, " paddr"}, rsp_paddr, ep);
    @(negedge clk);
    check({tag, " rsp one cycle"}, 32'(rsp_valid), 32'd0);
  endtask

  localparam logic [31:0] BASE = 32'h0001_0000;

  initial begin
    pte_mem[BASE + 0]  = {22'h000123, 10'b011};
    pte_mem[BASE + 4]  = {22'h3FFFFF, 10'h3F8 | 10'b111};
    pte_mem[BASE + 8]  = {22'h000001, 10'b110};
    pte_mem[BASE + 12] = {22'h000005, 10'b001};
    pte_mem[BASE + 16] = {22'h000007, 10'b011};
    pte_mem[BASE + 20] = {22'h000009, 10'b101};
    pte_mem[BASE + 60] = {22'h2AAAAA, 10'b011};

    repeat (3) @(negedge clk);
    check("R1 busy after reset", 32'(busy), 0);
    check("R1 mem_req after reset", 32'(mem_req), 0);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    xlate(32'h0000_0000, 1'b0, 0, 2'b01, 32'h0, "R1 size zero");

    ctx_write(BASE, 23'd16);
    xlate(32'h0000_02A5, 1'b0, 0, 2'b00, {22'h000123, 10'h2A5}, "R8 read ok");
    xlate(32'h0000_07FF, 1'b1, 3, 2'b00, 32'hFFFF_FFFF, "R5 write ok ignores 9:3");
    xlate(32'h0000_0800, 1'b0, 1, 2'b10, 32'h0, "R6 invalid with perms");
    xlate(32'h0000_0C00, 1'b0, 0, 2'b11, 32'h0, "R7 read no R");
    xlate(32'h0000_1000, 1'b1, 2, 2'b11, 32'h0, "R7 write no W");
    xlate(32'h0000_1010, 1'b0, 5, 2'b00, {22'h000007, 10'h010}, "R7 read with R");
    xlate(32'h0000_1400, 1'b1, 0, 2'b00, {22'h000009, 10'h000}, "R7 write with W");
    xlate(32'h0000_1400, 1'b0, 0, 2'b11, 32'h0, "R7 read W-only");
    xlate(32'h0000_3C01, 1'b0, 7, 2'b00, {22'h2AAAAA, 10'h001}, "R3 last entry");
    xlate(32'h0000_4000, 1'b0, 0, 2'b01, 32'h0, "R3 first out of range");
    xlate(32'hFFFF_FFFF, 1'b1, 0, 2'b01, 32'h0, "R3 top address");

    // R4: stray acks while idle are ignored
    stray_ack = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 no response from stray ack", 32'(rsp_valid), 0);
    xlate(32'h0000_0010, 1'b0, 4, 2'b00, {22'h000123, 10'h010}, "R4 stray ack long wait");
    stray_ack = 1'b0;

    // R2: request held during a busy translation is ignored
    ack_delay = 4;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0000_0C00; req_write = 1'b0;
    @(negedge clk);
    req_vaddr = 32'h0000_1010;
    while (!rsp_valid) @(negedge clk);
    req_valid = 1'b0;
    check("R2 first request result", 32'(rsp_fault), 32'(2'b11));
    @(negedge clk);
    check("R2 no second accept", 32'(busy), 0);

    // R10: context rewrite mid-flight
    ack_delay = 3;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0000_0123; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    ctx_we = 1'b1; ctx_base = 32'h2000_0000; ctx_size = 23'd0;
    @(negedge clk);
    ctx_we = 1'b0;
    while (!rsp_valid) @(negedge clk);
    check("R10 in-flight uses old ctx fault", 32'(rsp_fault), 0);
    check("R10 in-flight uses old ctx paddr", rsp_paddr, {22'h000123, 10'h123});
    @(negedge clk);
    xlate(32'h0000_0000, 1'b0, 0, 2'b01, 32'h0, "R10 new size applies");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule